// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip, clocked by the test clock. A 16-state sequencer is steered by the mode-select line. A 4-bit instruction register picks which data path sits between the serial input and the serial output: a 1-bit pass-through stage, a 32-bit identification word, or an external boundary chain. For that chain the block produces the path select and the capture, shift and update strobes. It also drives two pin-control flags. One places the chip's pins under test control. The other floats every output.

There is no dedicated test reset pin. The sequencer returns to its reset state in three ways: from a synchronous power-on reset input, from five rising edges with mode-select high (the usual walk), or from five consecutive rising edges on which mode-select and serial input are both high. Every return to reset makes the identification instruction active. Serial output changes on the falling edge of the test clock and is enabled only while a register is shifting.

Top module: `tap_controller`

## Requirements
- R1: While `por` is high at a rising edge of `tck`, the sequencer enters Test-Logic-Reset. From any state, five rising edges with `tms`=1 also reach Test-Logic-Reset. Other transitions follow the standard 16-state graph.
- R2: Five consecutive rising edges with both `tms` and `tdi` high place the sequencer in Test-Logic-Reset.
- R3: In Test-Logic-Reset the active instruction becomes IDCODE. `test_mode`, `force_float`, `tdo_en` and `bsr_sel` read 0.
- R4: IDCODE (0001) selects a 32-bit word holding version[31:28], part[27:12], maker[11:1] and 1 in bit 0. The word is loaded in Capture-DR and shifted out least-significant bit first.
- R5: Capture-IR loads 0001 into the instruction shifter, which shifts out least-significant bit first. The new instruction takes effect on the falling edge of `tck` in Update-IR, and not earlier.
- R6: EXTEST (0000) and SAMPLE (0010) route the boundary chain: `bsr_sel`=1, and in Shift-DR `tdo` follows `bsr_so`.
- R7: BYPASS (1111), TRIBYP (0011) and SETBYP (0100) route the 1-bit bypass stage. It captures 0, so the first bit out is 0 and each later bit is `tdi` delayed by one clock.
- R8: `test_mode` is 1 only for EXTEST and SETBYP. `force_float` is 1 only for TRIBYP.
- R9: Any other (reserved) code acts as BYPASS, with both pin-control flags at 0.
- R10: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 exactly while in Shift-IR or Shift-DR. Otherwise `tdo` is 0.
- R11: `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary chain is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Synchronous active-high power-on reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| test_mode | output | 1 | Pins driven from boundary cells |
| force_float | output | 1 | All outputs floated |

## Verification
The assertions assume that `por` is held high from time zero through the first clock edges. They also assume that `tms` and `tdi` change only away from the rising edge of `tck`, so every rising edge samples settled values. The bench keeps reset asserted for several cycles at start-up. It changes inputs only two time units after a falling edge and reads outputs at the same point, so each read falls after the falling-edge update of `tdo`, `tdo_en` and the instruction.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
    localparam logic [IR_W-1:0] OP_TRIBYP = 4'b0011;
    localparam logic [IR_W-1:0] OP_SETBYP = 4'b0100;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] { PATH_BYPASS, PATH_IDENT, PATH_BOUNDARY } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     pins_test;
        logic     pins_float;
    } instr_ctl_t;

    function automatic instr_ctl_t decode_instr(input logic [IR_W-1:0] code);
        instr_ctl_t c;
        c = '{path: PATH_BYPASS, pins_test: 1'b0, pins_float: 1'b0};
        case (code)
            OP_EXTEST: begin c.path = PATH_BOUNDARY; c.pins_test = 1'b1; end
            OP_IDCODE: c.path = PATH_IDENT;
            OP_SAMPLE: c.path = PATH_BOUNDARY;
            OP_TRIBYP: c.pins_float = 1'b1;
            OP_SETBYP: c.pins_test = 1'b1;
            default:   c.path = PATH_BYPASS;
        endcase
        return c;
    endfunction

    function automatic tap_state_e step_state(input tap_state_e s, input logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       tck,
    input  logic       por,
    input  logic       tms,
    input  logic       tdi,
    output tap_state_e state
);
    localparam int CW = $clog2(RESET_RUN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(RESET_RUN - 1);

    logic [CW-1:0] run_q;
    logic          both_high;

    assign both_high = tms & tdi;

    always_ff @(posedge tck) begin
        if (por) begin
            state <= ST_TLR;
            run_q <= '0;
        end else begin
            if (both_high && run_q == RUN_LAST)
                state <= ST_TLR;
            else
                state <= step_state(state, tms);
            if (!both_high)
                run_q <= '0;
            else if (run_q != RUN_LAST)
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            por,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            sh_lsb,
    output logic [IR_W-1:0] instr
);
    logic [IR_W-1:0] sh_q;

    always_ff @(posedge tck) begin
        if (por)
            sh_q <= IR_CAPTURE;
        else if (state == ST_CAP_IR)
            sh_q <= IR_CAPTURE;
        else if (state == ST_SH_IR)
            sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (por || state == ST_TLR)
            instr <= OP_IDCODE;
        else if (state == ST_UPD_IR)
            instr <= sh_q;
    end

    assign sh_lsb = sh_q[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [3:0]  VERSION = 4'h1,
    parameter logic [15:0] PART    = 16'h0001,
    parameter logic [10:0] MAKER   = 11'h001
) (
    input  logic       tck,
    input  logic       por,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       tdi,
    output logic       byp_q,
    output logic       id_lsb
);
    localparam logic [31:0] ID_WORD = {VERSION, PART, MAKER, 1'b1};

    logic [31:0] id_q;

    always_ff @(posedge tck) begin
        if (por) begin
            byp_q <= 1'b0;
            id_q  <= ID_WORD;
        end else begin
            if (path == PATH_BYPASS) begin
                if (state == ST_CAP_DR)
                    byp_q <= 1'b0;
                else if (state == ST_SH_DR)
                    byp_q <= tdi;
            end
            if (path == PATH_IDENT) begin
                if (state == ST_CAP_DR)
                    id_q <= ID_WORD;
                else if (state == ST_SH_DR)
                    id_q <= {tdi, id_q[31:1]};
            end
        end
    end

    assign id_lsb = id_q[0];
endmodule

// File: rtl/tap_controller.sv
module tap_controller
    import tap_pkg::*;
#(
    parameter logic [3:0]  VERSION   = 4'h1,
    parameter logic [15:0] PART      = 16'h0001,
    parameter logic [10:0] MAKER     = 11'h001,
    parameter int          RESET_RUN = 5
) (
    input  logic tck,
    input  logic por,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_so,
    output logic tdo,
    output logic tdo_en,
    output logic bsr_sel,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic test_mode,
    output logic force_float
);
    tap_state_e      cur_state;
    logic [IR_W-1:0] instr_q;
    logic            ir_lsb, byp_bit, id_bit, dr_bit;
    instr_ctl_t      ctl;

    tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .state(cur_state)
    );

    tap_ir u_ir (
        .tck(tck), .por(por), .state(cur_state), .tdi(tdi),
        .sh_lsb(ir_lsb), .instr(instr_q)
    );

    assign ctl = decode_instr(instr_q);

    tap_dr #(.VERSION(VERSION), .PART(PART), .MAKER(MAKER)) u_dr (
        .tck(tck), .por(por), .state(cur_state), .path(ctl.path), .tdi(tdi),
        .byp_q(byp_bit), .id_lsb(id_bit)
    );

    always_comb begin
        case (ctl.path)
            PATH_IDENT:    dr_bit = id_bit;
            PATH_BOUNDARY: dr_bit = bsr_so;
            default:       dr_bit = byp_bit;
        endcase
    end

    always_ff @(negedge tck) begin
        if (por) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (cur_state == ST_SH_IR) || (cur_state == ST_SH_DR);
            case (cur_state)
                ST_SH_IR: tdo <= ir_lsb;
                ST_SH_DR: tdo <= dr_bit;
                default:  tdo <= 1'b0;
            endcase
        end
    end

    assign bsr_sel     = (ctl.path == PATH_BOUNDARY);
    assign bsr_capture = bsr_sel && (cur_state == ST_CAP_DR);
    assign bsr_shift   = bsr_sel && (cur_state == ST_SH_DR);
    assign bsr_update  = bsr_sel && (cur_state == ST_UPD_DR);
    assign test_mode   = ctl.pins_test;
    assign force_float = ctl.pins_float;
endmodule

// File: rtl/tap_controller_chk.sv
module tap_controller_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            por,
    input logic            tms,
    input logic            tdi,
    input tap_state_e      state,
    input logic [IR_W-1:0] instr,
    input logic            tdo_en,
    input logic            bsr_sel,
    input logic            bsr_capture,
    input logic            force_float
);
    logic [2:0] hi_run;

    always_ff @(posedge tck) begin
        if (por)
            hi_run <= '0;
        else if (!(tms && tdi))
            hi_run <= '0;
        else if (hi_run != 3'd7)
            hi_run <= hi_run + 1'b1;
    end

    assert_por_reset_R1: assert property (@(posedge tck) por |=> state == ST_TLR);

    assert_five_high_R2: assert property (@(posedge tck) disable iff (por)
        (hi_run >= 3'd4 && tms && tdi) |=> state == ST_TLR);

    assert_reset_instr_R3: assert property (@(posedge tck) disable iff (por)
        state == ST_TLR |-> instr == OP_IDCODE);

    assert_instr_hold_R5: assert property (@(posedge tck) disable iff (por)
        !(state == ST_UPD_IR || state == ST_TLR) |-> $stable(instr));

    assert_float_no_bsr_R8: assert property (@(posedge tck) disable iff (por)
        force_float |-> !bsr_sel);

    assert_tdo_en_R10: assert property (@(posedge tck) disable iff (por)
        tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

    assert_capture_next_R11: assert property (@(posedge tck) disable iff (por)
        bsr_capture |=> (state == ST_SH_DR || state == ST_EX1_DR));
endmodule

bind tap_controller tap_controller_chk u_chk (
    .tck(tck), .por(por), .tms(tms), .tdi(tdi), .state(cur_state), .instr(instr_q),
    .tdo_en(tdo_en), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture), .force_float(force_float)
);

// File: tb/sim_tap_controller.sv
module sim_tap_controller;
    localparam logic [3:0]  VER  = 4'h3;
    localparam logic [15:0] PRT  = 16'hC0DE;
    localparam logic [10:0] MKR  = 11'h2A5;
    localparam logic [31:0] ID_EXP = {VER, PRT, MKR, 1'b1};

    logic tck = 1'b0, por = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic bsr_so;
    logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, test_mode, force_float;

    assign bsr_so = ~tdi;

    tap_controller #(.VERSION(VER), .PART(PRT), .MAKER(MKR), .RESET_RUN(5)) u0 (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .bsr_so(bsr_so), .tdo(tdo),
        .tdo_en(tdo_en), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update), .test_mode(test_mode),
        .force_float(force_float)
    );

    always #10 tck = ~tck;

    int checks = 0, failures = 0;
    logic finished = 1'b0;

    typedef struct { string req; logic [31:0] val; } exp_t;
    exp_t sb_q[$];

    task automatic expect_item(input string req, input logic [31:0] v);
        exp_t e;
        e.req = req; e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic monitor_item(input logic [31:0] act);
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (act !== e.val) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", e.req, act, e.val);
        end
    endtask

    logic last_tdo;
    logic [1:0] flags_pre, flags_post;
    logic en_all;
    logic [2:0] strobes;

    task automatic cyc(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck);
        @(negedge tck);
        #2;
        last_tdo = tdo;
    endtask

    task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
        cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0);
        en_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cap[i] = last_tdo;
            en_all &= tdo_en;
            cyc(i == 3, code[i]);
        end
        flags_pre = {test_mode, force_float};
        cyc(1, 0);
        flags_post = {test_mode, force_float};
        cyc(0, 0);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        cyc(1, 0); cyc(0, 0);
        strobes[2] = bsr_capture;
        cyc(0, 0);
        en_all = 1'b1;
        strobes[1] = bsr_shift;
        for (int i = 0; i < n; i++) begin
            dout[i] = last_tdo;
            en_all &= tdo_en;
            cyc(i == n - 1, din[i]);
        end
        cyc(1, 0);
        strobes[0] = bsr_update;
        cyc(0, 0);
    endtask

    initial begin
        logic [3:0]  cap;
        logic [31:0] dout;
        logic [7:0]  pat;
        pat = 8'b1011_0010;
        #2;
        repeat (3) cyc(1, 0);
        por = 1'b0;
        // R3 / R10: reset state
        expect_item("R3 reset outputs", 32'h0);
        monitor_item({28'h0, test_mode, force_float, tdo_en, bsr_sel});
        cyc(0, 0);
        // R4: default instruction reads identification word
        expect_item("R4 idcode after reset", ID_EXP);
        shift_dr(32, 32'h0, dout);
        monitor_item(dout);
        expect_item("R10 tdo_en during shift", 32'h1);
        monitor_item({31'h0, en_all});
        expect_item("R10 tdo_en idle low", 32'h0);
        monitor_item({30'h0, tdo_en, tdo});
        // R5: capture pattern, BYPASS path
        shift_ir(4'b1111, cap);
        expect_item("R5 ir capture 0001", 32'h1);
        monitor_item({28'h0, cap});
        expect_item("R10 tdo_en in shift-ir", 32'h1);
        monitor_item({31'h0, en_all});
        shift_dr(8, {24'h0, pat}, dout);
        expect_item("R7 bypass delay", {24'h0, pat[6:0], 1'b0});
        monitor_item(dout);
        expect_item("R11 no strobes on bypass", 32'h0);
        monitor_item({29'h0, strobes});
        // EXTEST: timing of update, test mode, boundary path
        shift_ir(4'b0000, cap);
        expect_item("R5 flags unchanged before update-ir", 32'h0);
        monitor_item({30'h0, flags_pre});
        expect_item("R8 extest flags", 32'h2);
        monitor_item({30'h0, flags_post});
        expect_item("R6 extest bsr_sel", 32'h1);
        monitor_item({31'h0, bsr_sel});
        shift_dr(6, 32'h2D, dout);
        expect_item("R6 extest tdo follows bsr_so", {26'h0, ~6'h2D & 6'h1F, 1'b1} & 32'h3F);
        monitor_item(dout);
        // SAMPLE
        shift_ir(4'b0010, cap);
        expect_item("R5 flags still extest before update", 32'h2);
        monitor_item({30'h0, flags_pre});
        expect_item("R8 sample flags", 32'h0);
        monitor_item({30'h0, flags_post});
        shift_dr(5, 32'h13, dout);
        expect_item("R6 sample tdo follows bsr_so", {27'h0, ~4'h3, 1'b1});
        monitor_item(dout);
        expect_item("R11 boundary strobes", 32'h7);
        monitor_item({29'h0, strobes});
        // TRIBYP
        shift_ir(4'b0011, cap);
        expect_item("R8 tribyp flags", 32'h1);
        monitor_item({30'h0, flags_post});
        shift_dr(8, {24'h0, ~pat}, dout);
        expect_item("R7 tribyp bypass", {24'h0, ~pat[6:0], 1'b0});
        monitor_item(dout);
        // SETBYP
        shift_ir(4'b0100, cap);
        expect_item("R8 setbyp flags", 32'h2);
        monitor_item({30'h0, flags_post});
        shift_dr(8, {24'h0, pat}, dout);
        expect_item("R7 setbyp bypass", {24'h0, pat[6:0], 1'b0});
        monitor_item(dout);
        // Reserved code
        shift_ir(4'b0110, cap);
        expect_item("R9 reserved flags", 32'h0);
        monitor_item({29'h0, bsr_sel, flags_post});
        shift_dr(8, {24'h0, pat}, dout);
        expect_item("R9 reserved acts as bypass", {24'h0, pat[6:0], 1'b0});
        monitor_item(dout);
        // R2: TMS and TDI high for five edges
        shift_ir(4'b0000, cap);
        repeat (5) cyc(1, 1);
        expect_item("R2 five-high reset flags", 32'h0);
        monitor_item({29'h0, bsr_sel, test_mode, force_float});
        cyc(0, 0);
        shift_dr(32, 32'h0, dout);
        expect_item("R2 idcode after five-high reset", ID_EXP);
        monitor_item(dout);
        // R1: TMS alone for five edges
        shift_ir(4'b0100, cap);
        repeat (5) cyc(1, 0);
        expect_item("R1 tms walk to reset", 32'h0);
        monitor_item({30'h0, test_mode, force_float});
        // R1: power-on reset mid-operation
        cyc(0, 0);
        shift_ir(4'b0011, cap);
        por = 1'b1;
        cyc(0, 0);
        por = 1'b0;
        expect_item("R1 por clears instruction", 32'h0);
        monitor_item({30'h0, test_mode, force_float});
        cyc(0, 0);
        shift_dr(32, 32'h0, dout);
        expect_item("R3 idcode after por", ID_EXP);
        monitor_item(dout);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule